// File: doc/BRIEF.md
# Scan-Chain SRAM Test Controller

This block lets a tester exercise on-chip memories through very few pins. A 112-bit command word describes one complete two-port memory transaction: a memory selector, then for each of two ports an address, a data word, an active-low chip select, an active-low write enable and a byte-lane write mask. The command enters either bit-serially, most significant bit first, while scan is enabled, or in one cycle from a wide debug bus. A source-select input decides which of the two paths is live.

Raising the access strobe for one cycle applies the held command to the memory named by the selector. On the next clock the read results are folded back into the data fields of the same register. Every other field keeps its command value. The whole word can then be shifted out on the serial output, most significant bit first. Small behavioural memories stand in for the real macros: five dual-port memories, three single-port memories and one 64-bit single-port memory, all inferable as block RAM.

Top module: `sram_scan_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the whole command register and drives `scan_out` to 0.
- R2: With `src_sel`=1 and `scan_en`=1, the register shifts one place toward the MSB on each clock and takes `scan_in` into bit 0. After 112 clocks the first bit driven sits in bit 111.
- R3: `scan_out` always presents bit 111 of the register. Each shift clock moves the next lower bit onto `scan_out`, so a full word leaves MSB first in 112 clocks.
- R4: With `src_sel`=0 and `par_load`=1, the register takes all 112 bits of `par_data` on the clock. `par_load` has no effect while `src_sel`=1, and `scan_en` has no effect while `src_sel`=0.
- R5: The word layout from bit 111 down is: selector [111:108]; port 0 with address [107:92], data [91:60], chip select [59], write enable [58] and mask [57:54]; port 1 with address [53:38], data [37:6], chip select [5], write enable [4] and mask [3:0].
- R6: Chip select and write enable are active low. Chip select 0 with write enable 0 writes, and mask bit k enables data byte k (bits 8k+7..8k). Chip select 0 with write enable 1 reads. Chip select 1 leaves the port idle.
- R7: A clock with `mem_go`=1 performs the access. The following clock replaces the data field of each reading port with the read word and leaves all other fields unchanged. No shift or parallel load happens in either of these two clocks.
- R8: Selector values 0 to 4 address five separate dual-port memories. Both ports act on the selected memory in the same access.
- R9: Selector values 8 to 10 address three single-port memories. Only the port-0 fields act. Port-1 fields, including a write request, are ignored, and the port-1 data field comes back unchanged.
- R10: Selector 11 addresses a 64-bit single-port memory. A write stores the 32-bit data zero-extended, with mask bits 0 to 3 enabling the low four bytes and the upper four bytes written with zero whenever any mask bit is set. A read returns bits 63:48 of the word in data bits 31:16 and bits 15:0 of the word in data bits 15:0.
- R11: Any other selector value accesses no memory and leaves the register unchanged.
- R12: When no reset, access, capture, enabled shift or enabled load applies, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the memories |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Command source: 0 selects the parallel bus, 1 selects the serial path |
| scan_en | input | 1 | Serial shift enable |
| scan_in | input | 1 | Serial command input |
| par_load | input | 1 | Parallel load strobe |
| par_data | input | 112 | Parallel command word |
| mem_go | input | 1 | Access strobe, one clock |
| scan_out | output | 1 | Serial output, bit 111 of the register |

## Verification
The bench writes with a partial byte mask and reads the word back. A design that ignored lane enables or mis-ordered the lanes would return the wrong bytes. It checks that a port-1 write to a single-port memory leaves the memory and the port-1 data field untouched, and that an unmapped selector writes nothing into memory 0. A design that aliased those selectors or honoured port 1 would show changed read data. It reads the wide memory after a zero-extended write, so a design that returned the plain low word instead of the high and low halves would miscompare. It also applies the inactive-path strobes and a mid-shift reset, which a design with the source select decoded wrongly, or a reset that missed the output, would corrupt.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int CMD_W    = 112;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int MASK_W   = 4;
  localparam int SEL_W    = 4;
  localparam int SP_BASE  = 8;
  localparam int WIDE_SEL = 11;
  localparam int WIDE_W   = 64;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              cs_n;
    logic              we_n;
    logic [MASK_W-1:0] mask;
  } port_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    port_t            p0;
    port_t            p1;
  } cmd_t;

  typedef enum logic [1:0] {MC_NONE, MC_DUAL, MC_SINGLE, MC_WIDE} mclass_e;

  function automatic mclass_e classify(input logic [SEL_W-1:0] sel,
                                       input int n_dual, input int n_single);
    int s;
    s = int'(sel);
    if (s < n_dual) return MC_DUAL;
    if (s >= SP_BASE && s < SP_BASE + n_single) return MC_SINGLE;
    if (s == WIDE_SEL) return MC_WIDE;
    return MC_NONE;
  endfunction
endpackage

// File: rtl/sst_dp_mem.sv
module sst_dp_mem #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [LANES-1:0] a_mask,
  input  logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_din,
  output logic [DW-1:0]    a_dout,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [LANES-1:0] b_mask,
  input  logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_din,
  output logic [DW-1:0]    b_dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port B is written after port A, so B wins on a same-address double write.
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) begin
        for (int l = 0; l < LANES; l++)
          if (a_mask[l]) mem[a_addr][l*8 +: 8] <= a_din[l*8 +: 8];
      end else begin
        a_dout <= mem[a_addr];
      end
    end
    if (b_en) begin
      if (b_we) begin
        for (int l = 0; l < LANES; l++)
          if (b_mask[l]) mem[b_addr][l*8 +: 8] <= b_din[l*8 +: 8];
      end else begin
        b_dout <= mem[b_addr];
      end
    end
  end
endmodule

// File: rtl/sst_sp_mem.sv
module sst_sp_mem #(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [LANES-1:0] mask,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int l = 0; l < LANES; l++)
          if (mask[l]) mem[addr][l*8 +: 8] <= din[l*8 +: 8];
      end else begin
        dout <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/sst_mem_bank.sv
module sst_mem_bank
  import sst_pkg::*;
#(
  parameter int NUM_DUAL   = 5,
  parameter int NUM_SINGLE = 3,
  parameter int MEM_AW     = 4
) (
  input  logic              clk,
  input  logic              access,
  input  cmd_t              cmd,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);
  localparam int WIDE_LANES = WIDE_W / 8;
  localparam int PAD_W      = WIDE_W - DATA_W;

  logic [DATA_W-1:0] dq0 [NUM_DUAL];
  logic [DATA_W-1:0] dq1 [NUM_DUAL];
  logic [DATA_W-1:0] sq  [NUM_SINGLE];
  logic [WIDE_W-1:0] wq;

  logic [MEM_AW-1:0] a0, a1;
  logic              rq0, wr0, rq1, wr1;

  assign a0  = cmd.p0.addr[MEM_AW-1:0];
  assign a1  = cmd.p1.addr[MEM_AW-1:0];
  assign rq0 = access & ~cmd.p0.cs_n;
  assign rq1 = access & ~cmd.p1.cs_n;
  assign wr0 = ~cmd.p0.we_n;
  assign wr1 = ~cmd.p1.we_n;

  for (genvar g = 0; g < NUM_DUAL; g++) begin : g_dual
    logic hit;
    assign hit = (cmd.sel == SEL_W'(g));
    sst_dp_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .a_en  (rq0 & hit), .a_we(wr0), .a_mask(cmd.p0.mask), .a_addr(a0),
      .a_din (cmd.p0.data), .a_dout(dq0[g]),
      .b_en  (rq1 & hit), .b_we(wr1), .b_mask(cmd.p1.mask), .b_addr(a1),
      .b_din (cmd.p1.data), .b_dout(dq1[g])
    );
  end

  for (genvar g = 0; g < NUM_SINGLE; g++) begin : g_single
    logic hit;
    assign hit = (cmd.sel == SEL_W'(SP_BASE + g));
    sst_sp_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
      .clk(clk), .en(rq0 & hit), .we(wr0), .mask(cmd.p0.mask), .addr(a0),
      .din(cmd.p0.data), .dout(sq[g])
    );
  end

  logic wide_hit;
  assign wide_hit = (cmd.sel == SEL_W'(WIDE_SEL));

  sst_sp_mem #(.AW(MEM_AW), .DW(WIDE_W)) u_wide (
    .clk  (clk),
    .en   (rq0 & wide_hit),
    .we   (wr0),
    .mask ({{(WIDE_LANES - MASK_W){|cmd.p0.mask}}, cmd.p0.mask}),
    .addr (a0),
    .din  ({{PAD_W{1'b0}}, cmd.p0.data}),
    .dout (wq)
  );

  // The selector is held in the register from access to capture.
  always_comb begin
    rd0 = '0;
    rd1 = '0;
    for (int i = 0; i < NUM_DUAL; i++)
      if (cmd.sel == SEL_W'(i)) begin
        rd0 = dq0[i];
        rd1 = dq1[i];
      end
    for (int i = 0; i < NUM_SINGLE; i++)
      if (cmd.sel == SEL_W'(SP_BASE + i)) rd0 = sq[i];
    if (wide_hit) rd0 = {wq[WIDE_W-1 -: 16], wq[15:0]};
  end

  logic unused_bits;
  assign unused_bits = ^{cmd.p0.addr[ADDR_W-1:MEM_AW], cmd.p1.addr[ADDR_W-1:MEM_AW],
                         wq[WIDE_W-17:16]};
endmodule

// File: rtl/sram_scan_ctrl.sv
module sram_scan_ctrl
  import sst_pkg::*;
#(
  parameter int NUM_DUAL   = 5,
  parameter int NUM_SINGLE = 3,
  parameter int MEM_AW     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_sel,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic             par_load,
  input  logic [CMD_W-1:0] par_data,
  input  logic             mem_go,
  output logic             scan_out
);
  cmd_t              cmd_q, cmd_d;
  logic              cap_q, scan_q, access;
  mclass_e           cls;
  logic [DATA_W-1:0] rd0, rd1;

  assign access = mem_go & ~cap_q;
  assign cls    = classify(cmd_q.sel, NUM_DUAL, NUM_SINGLE);

  sst_mem_bank #(
    .NUM_DUAL(NUM_DUAL), .NUM_SINGLE(NUM_SINGLE), .MEM_AW(MEM_AW)
  ) u_bank (
    .clk(clk), .access(access), .cmd(cmd_q), .rd0(rd0), .rd1(rd1)
  );

  always_comb begin
    cmd_d = cmd_q;
    if (cap_q) begin
      if (cls != MC_NONE && !cmd_q.p0.cs_n && cmd_q.p0.we_n) cmd_d.p0.data = rd0;
      if (cls == MC_DUAL && !cmd_q.p1.cs_n && cmd_q.p1.we_n) cmd_d.p1.data = rd1;
    end else if (access) begin
      cmd_d = cmd_q;  // memories sample the held command this cycle
    end else if (src_sel && scan_en) begin
      cmd_d = {cmd_q[CMD_W-2:0], scan_in};
    end else if (!src_sel && par_load) begin
      cmd_d = par_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      cap_q  <= 1'b0;
      scan_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      cap_q  <= access;
      scan_q <= cmd_d[CMD_W-1];
    end
  end

  assign scan_out = scan_q;
endmodule

// File: rtl/sram_scan_ctrl_chk.sv
module sram_scan_ctrl_chk #(
  parameter int NUM_SINGLE = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         src_sel,
  input logic         scan_en,
  input logic         scan_in,
  input logic         par_load,
  input logic [111:0] par_data,
  input logic         mem_go,
  input logic         scan_out,
  input logic [111:0] cmd_q,
  input logic         cap_q
);
  logic shifting, loading, single_sel;
  assign shifting   = src_sel && scan_en && !mem_go && !cap_q;
  assign loading    = !src_sel && par_load && !mem_go && !cap_q;
  assign single_sel = (int'(cmd_q[111:108]) >= 8) && (int'(cmd_q[111:108]) < 8 + NUM_SINGLE);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!scan_out && cmd_q == '0));
  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    shifting |=> cmd_q[0] == $past(scan_in));
  p_shift_out_r3: assert property (@(posedge clk) disable iff (rst)
    shifting |=> scan_out == $past(cmd_q[110]));
  p_par_load_r4: assert property (@(posedge clk) disable iff (rst)
    loading |=> cmd_q == $past(par_data));
  p_go_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_go && !cap_q) |=> (cap_q && $stable(cmd_q)));
  p_capture_fields_r7: assert property (@(posedge clk) disable iff (rst)
    cap_q |=> (cmd_q[111:92] == $past(cmd_q[111:92]) &&
               cmd_q[59:38] == $past(cmd_q[59:38]) &&
               cmd_q[5:0] == $past(cmd_q[5:0])));
  p_single_port1_r9: assert property (@(posedge clk) disable iff (rst)
    (cap_q && single_sel) |=> cmd_q[37:6] == $past(cmd_q[37:6]));
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!mem_go && !cap_q && !(src_sel && scan_en) && !(!src_sel && par_load))
      |=> $stable(cmd_q));
endmodule

bind sram_scan_ctrl sram_scan_ctrl_chk #(.NUM_SINGLE(NUM_SINGLE)) u_chk (
  .clk(clk), .rst(rst), .src_sel(src_sel), .scan_en(scan_en), .scan_in(scan_in),
  .par_load(par_load), .par_data(par_data), .mem_go(mem_go), .scan_out(scan_out),
  .cmd_q(cmd_q), .cap_q(cap_q)
);

// File: tb/sram_scan_ctrl_tb.sv
module sram_scan_ctrl_tb;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 100000;
  localparam int NVEC         = 16;
  localparam logic [1:0] WR = 2'b00, RD = 2'b01, ID = 2'b11;  // {cs_n, we_n}

  typedef struct packed {
    logic         par;
    logic [111:0] cmd;
    logic [111:0] exp;
  } vec_t;

  function automatic logic [111:0] mk(
    input logic [3:0] s,
    input logic [15:0] a0, input logic [31:0] d0, input logic [1:0] o0, input logic [3:0] m0,
    input logic [15:0] a1, input logic [31:0] d1, input logic [1:0] o1, input logic [3:0] m1);
    return {s, a0, d0, o0, m0, a1, d1, o1, m1};
  endfunction

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, mk(0, 1, 32'hAABBCCDD, WR, 4'hF, 2, 32'h01020304, WR, 4'hF),
            mk(0, 1, 32'hAABBCCDD, WR, 4'hF, 2, 32'h01020304, WR, 4'hF)},
    '{1'b1, mk(0, 1, 32'h0, RD, 4'h0, 2, 32'h0, RD, 4'h0),
            mk(0, 1, 32'hAABBCCDD, RD, 4'h0, 2, 32'h01020304, RD, 4'h0)},
    '{1'b0, mk(0, 1, 32'h11223344, WR, 4'h5, 0, 32'hDEAD0000, ID, 4'h0),
            mk(0, 1, 32'h11223344, WR, 4'h5, 0, 32'hDEAD0000, ID, 4'h0)},
    '{1'b1, mk(0, 1, 32'h0, RD, 4'h0, 1, 32'h0, RD, 4'h0),
            mk(0, 1, 32'hAA22CC44, RD, 4'h0, 1, 32'hAA22CC44, RD, 4'h0)},
    '{1'b0, mk(1, 3, 32'h55555555, WR, 4'hF, 0, 32'h0, ID, 4'h0),
            mk(1, 3, 32'h55555555, WR, 4'hF, 0, 32'h0, ID, 4'h0)},
    '{1'b1, mk(4, 3, 32'hCAFEF00D, WR, 4'hF, 0, 32'h0, ID, 4'h0),
            mk(4, 3, 32'hCAFEF00D, WR, 4'hF, 0, 32'h0, ID, 4'h0)},
    '{1'b0, mk(1, 3, 32'h0, RD, 4'h0, 0, 32'h24681357, ID, 4'h0),
            mk(1, 3, 32'h55555555, RD, 4'h0, 0, 32'h24681357, ID, 4'h0)},
    '{1'b1, mk(4, 3, 32'h0, RD, 4'h0, 3, 32'h0, RD, 4'h0),
            mk(4, 3, 32'hCAFEF00D, RD, 4'h0, 3, 32'hCAFEF00D, RD, 4'h0)},
    '{1'b0, mk(8, 5, 32'h0BADBEEF, WR, 4'hF, 5, 32'h99999999, WR, 4'hF),
            mk(8, 5, 32'h0BADBEEF, WR, 4'hF, 5, 32'h99999999, WR, 4'hF)},
    '{1'b1, mk(8, 5, 32'h0, RD, 4'h0, 5, 32'h77777777, RD, 4'h0),
            mk(8, 5, 32'h0BADBEEF, RD, 4'h0, 5, 32'h77777777, RD, 4'h0)},
    '{1'b0, mk(10, 0, 32'hA5A5A5A5, WR, 4'hF, 0, 32'h0, ID, 4'h0),
            mk(10, 0, 32'hA5A5A5A5, WR, 4'hF, 0, 32'h0, ID, 4'h0)},
    '{1'b1, mk(10, 0, 32'h0, RD, 4'h0, 0, 32'h0, ID, 4'h0),
            mk(10, 0, 32'hA5A5A5A5, RD, 4'h0, 0, 32'h0, ID, 4'h0)},
    '{1'b0, mk(11, 2, 32'h12345678, WR, 4'hF, 0, 32'h0, ID, 4'h0),
            mk(11, 2, 32'h12345678, WR, 4'hF, 0, 32'h0, ID, 4'h0)},
    '{1'b1, mk(11, 2, 32'hFFFFFFFF, RD, 4'h0, 0, 32'h0, ID, 4'h0),
            mk(11, 2, 32'h00005678, RD, 4'h0, 0, 32'h0, ID, 4'h0)},
    '{1'b0, mk(6, 2, 32'hFFFFFFFF, WR, 4'hF, 2, 32'h2468ACE0, RD, 4'h0),
            mk(6, 2, 32'hFFFFFFFF, WR, 4'hF, 2, 32'h2468ACE0, RD, 4'h0)},
    '{1'b1, mk(0, 2, 32'h0, RD, 4'h0, 0, 32'h0, ID, 4'h0),
            mk(0, 2, 32'h01020304, RD, 4'h0, 0, 32'h0, ID, 4'h0)}
  };

  localparam string TAGS [NVEC] = '{
    "R2 R3 R5 R6 R8", "R4 R7 R8", "R6", "R6 R7 R8", "R2 R8", "R4 R8", "R7 R8", "R8",
    "R9", "R9", "R9", "R9", "R10", "R10", "R11", "R11"
  };

  logic         clk = 1'b0;
  logic         rst, src_sel, scan_en, scan_in, par_load, mem_go, scan_out;
  logic [111:0] par_data;
  int           n_vec = 0;
  int           n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_scan_ctrl u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .scan_en(scan_en), .scan_in(scan_in),
    .par_load(par_load), .par_data(par_data), .mem_go(mem_go), .scan_out(scan_out)
  );

  task automatic check(input string tag, input logic [111:0] act, input logic [111:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_in(input logic [111:0] v);
    src_sel = 1'b1;
    for (int j = 0; j < 112; j++) begin
      scan_in = v[111-j];
      scan_en = 1'b1;
      @(negedge clk);
    end
    scan_en = 1'b0;
    scan_in = 1'b0;
  endtask

  task automatic par_in(input logic [111:0] v);
    src_sel  = 1'b0;
    par_data = v;
    par_load = 1'b1;
    @(negedge clk);
    par_load = 1'b0;
  endtask

  task automatic fire();
    mem_go = 1'b1;
    @(negedge clk);
    mem_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic shift_out(output logic [111:0] v);
    src_sel = 1'b1;
    scan_in = 1'b0;
    for (int j = 0; j < 112; j++) begin
      v[111-j] = scan_out;
      scan_en = 1'b1;
      @(negedge clk);
    end
    scan_en = 1'b0;
  endtask

  task automatic run_all();
    logic [111:0] got, x;
    rst = 1'b1; src_sel = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
    par_load = 1'b0; par_data = '0; mem_go = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset scan_out", {111'b0, scan_out}, '0);
    shift_out(got);
    check("R1 reset register", got, '0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].par) par_in(VEC[i].cmd);
      else shift_in(VEC[i].cmd);
      check({TAGS[i], " R3 msb on scan_out"}, {111'b0, scan_out}, {111'b0, VEC[i].cmd[111]});
      fire();
      shift_out(got);
      check(TAGS[i], got, VEC[i].exp);
    end

    // R4 R12: parallel strobe while serial path selected, shift disabled
    x = mk(9, 16'hBEEF, 32'h01234567, ID, 4'hA, 16'h1234, 32'h89ABCDEF, ID, 4'h5);
    shift_in(x);
    src_sel = 1'b1; scan_en = 1'b0; par_load = 1'b1; par_data = ~x; scan_in = 1'b1;
    repeat (4) @(negedge clk);
    par_load = 1'b0;
    shift_out(got);
    check("R4 R12 par_load ignored on serial path", got, x);

    // R4: scan enable while parallel path selected
    shift_in(x);
    src_sel = 1'b0; scan_en = 1'b1; scan_in = 1'b1; par_load = 1'b0;
    repeat (4) @(negedge clk);
    scan_en = 1'b0;
    shift_out(got);
    check("R4 scan_en ignored on parallel path", got, x);

    // R1: reset in the middle of a shift
    src_sel = 1'b1; scan_in = 1'b1; scan_en = 1'b1;
    repeat (60) @(negedge clk);
    scan_en = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-shift reset scan_out", {111'b0, scan_out}, '0);
    shift_out(got);
    check("R1 mid-shift reset register", got, '0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule